// File: doc/BRIEF.md
# Glitch-Free Runtime Clock Prescaler

This block divides a fast source clock by a power of two. The CPU and the synchronous peripherals run on the divided clock, and software may change the ratio at any time through a small write port. A counter running on the undivided source clock forms the output. The output is a registered square wave, so no runt pulse can reach it. The block also gives a one-source-cycle enable pulse that lines up with each rising edge of the divided clock. Logic that runs on clock enables rather than a derived clock can use that pulse.

A new setting does not take effect when it is written. It is held as pending and is applied only when the output period in progress has ended. The old period therefore always runs to its full length, and the new one starts cleanly on a rising edge. If a second write arrives before the boundary, it replaces the pending value. Every output phase seen during a handover is exactly the length that either the old or the new setting gives.

Top module: `clk_prescaler`

## Requirements
- R1: While reset is asserted, `clk_div` and `clk_en` are low and the setting is code 0. The first rising edge of `clk_div` follows the first source edge after reset is released.
- R2: For a select code N from 0 to 7, each output period lasts 2^(N+1) source cycles. The high part and the low part each last 2^N cycles.
- R3: Select codes 8 to 15 are reserved and give a period of 256 source cycles, the same as code 7.
- R4: A write changes nothing in the period in progress. The new period length first appears in the period that starts at the next rising edge of `clk_div`.
- R5: During a change of setting, no high or low phase is shorter than half of the smaller of the old and new periods.
- R6: If several writes land within one output period, only the last one is applied at the boundary.
- R7: Suppose a write is sampled in the cycle that follows a rising edge, as logic clocked by `clk_div` would make it. Then the second rising edge after that first edge comes exactly T1+T2 source cycles after it, where T1 is the old period and T2 the new one. This lies inside the window from T1+T2 to T1+2*T2.
- R8: `clk_en` is high for exactly one source cycle per output period. That cycle is the first cycle in which `clk_div` is high after having been low.
- R9: A write sampled on the source edge that ends a period governs the period that starts at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the division select |
| sel_wdata | input | 4 | Division select code N (period 2^(N+1), codes above 7 give 256) |
| clk_div | output | 1 | Divided clock, 50% duty |
| clk_en | output | 1 | One-cycle pulse at each rising edge of `clk_div` |

## Verification
The bench writes random codes at random points in the period, covering all sixteen codes. Some of these writes come one after another with no gap. The bench measures every high and low phase and every period against the setting that should govern it, and it checks that the enable pulse tracks each rise. Writes landing on the closing edge of a period tell apart a design that drops them from one that applies them at once. Back-to-back writes show whether the last value or an earlier one is kept. Directed switches from fast to slow settings, and from slow to fast, each begun just after a rising edge, check the exact settling time. Reserved codes must act like the slowest setting.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int SEL_W   = 4,
  parameter int MAX_LOG = 7,
  localparam int CNT_W  = MAX_LOG + 1
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic             clk_div,
  output logic             clk_en
);

  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(MAX_LOG);

  logic [SEL_W-1:0] cur, pend, next_sel;
  logic             pend_v;
  logic [CNT_W-1:0] cnt, cnt_inc, last_cnt, half_cnt;
  logic             wrap, div_q, en_q;

  function automatic logic [SEL_W-1:0] clamp(input logic [SEL_W-1:0] c);
    return (c > SEL_TOP) ? SEL_TOP : c;
  endfunction

  assign last_cnt = CNT_W'((32'd2 << clamp(cur)) - 32'd1);
  assign half_cnt = CNT_W'(32'd1 << clamp(cur));
  assign cnt_inc  = cnt + 1'b1;
  assign wrap     = (cnt == last_cnt);
  assign next_sel = sel_we ? sel_wdata : (pend_v ? pend : cur);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      cnt    <= CNT_W'(1);
      div_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= wrap;
      if (wrap) begin
        cnt    <= '0;
        cur    <= next_sel;
        pend_v <= 1'b0;
        div_q  <= 1'b1;
      end else begin
        cnt   <= cnt_inc;
        div_q <= (cnt_inc < half_cnt);
        if (sel_we) begin
          pend   <= sel_wdata;
          pend_v <= 1'b1;
        end
      end
    end
  end

  assign clk_div = div_q;
  assign clk_en  = en_q;

endmodule

// File: rtl/clk_prescaler_chk.sv
module clk_prescaler_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             clk_div,
  input logic             clk_en,
  input logic [SEL_W-1:0] cur_sel
);

  logic       div_d, seen_fall;
  logic [8:0] run_len, hi_len;
  logic       toggled;

  assign toggled = (clk_div != div_d);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      div_d     <= 1'b0;
      run_len   <= 9'd1;
      hi_len    <= 9'd0;
      seen_fall <= 1'b0;
    end else begin
      div_d   <= clk_div;
      run_len <= toggled ? 9'd1 : run_len + 9'd1;
      if (!clk_div && div_d) begin
        hi_len    <= run_len;
        seen_fall <= 1'b1;
      end
    end
  end

  // R8
  en_at_rise_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    clk_en |-> (clk_div && !div_d));

  // R8
  rise_has_en_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(clk_div) |-> clk_en);

  // R2
  phase_pow2_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    toggled |-> ($countones(run_len) == 1));

  // R5
  equal_halves_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (clk_div && !div_d && seen_fall) |-> (run_len == hi_len));

  // R4
  switch_at_boundary_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    !$stable(cur_sel) |-> clk_en);

endmodule

bind clk_prescaler clk_prescaler_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_src (clk_src),
  .rst_n   (rst_n),
  .clk_div (clk_div),
  .clk_en  (clk_en),
  .cur_sel (cur)
);

// File: tb/test_clk_prescaler.sv
module test_clk_prescaler;

  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_we = 1'b0;
  logic [3:0] sel_wdata = 4'd0;
  wire        clk_div, clk_en;

  int checks = 0, failures = 0;
  int latest = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  clk_prescaler i_clk_prescaler (
    .clk_src(clk_src), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .clk_div(clk_div), .clk_en(clk_en)
  );

  always #5 clk_src = ~clk_src;

  function automatic int per_of(input int code);
    return (code > 7) ? 256 : (2 << code);
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // period tracker: outputs sampled 2 ns after each rising source edge
  bit prev_div = 1'b0, have_per = 1'b0, have_prev = 1'b0;
  int rise_cyc = 0, fall_cyc = 0, exp_per = 2, prev_per = 2, hi_len = 0;
  always @(posedge clk_src) begin
    #2;
    if (mon_on) begin
      bit rose, fell;
      cyc++;
      rose = clk_div && !prev_div;
      fell = !clk_div && prev_div;
      // R8
      check(clk_en == rose, "R8 enable vs rise", clk_en, rose);
      if (fell) begin
        hi_len   = cyc - rise_cyc;
        fall_cyc = cyc;
      end
      if (rose) begin
        if (have_per) begin
          // R2 R3 R4 R6 R9: period governed by the setting in force at its start
          check(cyc - rise_cyc == exp_per, "R2/R3/R4/R6/R9 period", cyc - rise_cyc, exp_per);
          check(hi_len == exp_per / 2, "R2 high time", hi_len, exp_per / 2);
          if (have_prev) begin
            // R5
            check(hi_len >= min2(prev_per, exp_per) / 2, "R5 high floor", hi_len,
                  min2(prev_per, exp_per) / 2);
            check(cyc - fall_cyc >= min2(prev_per, exp_per) / 2, "R5 low floor",
                  cyc - fall_cyc, min2(prev_per, exp_per) / 2);
          end
          prev_per  = exp_per;
          have_prev = 1'b1;
        end
        exp_per  = per_of(latest);
        rise_cyc = cyc;
        have_per = 1'b1;
      end
      prev_div = clk_div;
    end
  end

  task automatic write_sel(input int code);
    sel_we    = 1'b1;
    sel_wdata = 4'(code);
    latest    = code;
    @(negedge clk_src);
    sel_we = 1'b0;
  endtask

  task automatic wait_rise();
    do @(negedge clk_src); while (!clk_en);
  endtask

  // R7: write right after a rise, then measure to the second following rise
  task automatic settle(input int from_code, input int to_code);
    int n;
    write_sel(from_code);
    wait_rise();
    wait_rise();
    wait_rise();
    write_sel(to_code);
    n = 1;
    while (!clk_en) begin @(negedge clk_src); n++; end
    check(n == per_of(from_code), "R7 old period completes", n, per_of(from_code));
    @(negedge clk_src); n++;
    while (!clk_en) begin @(negedge clk_src); n++; end
    check(n == per_of(from_code) + per_of(to_code), "R7 settle time", n,
          per_of(from_code) + per_of(to_code));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_src);
    // R1
    check(clk_div == 1'b0, "R1 reset clk_div", clk_div, 0);
    check(clk_en == 1'b0, "R1 reset clk_en", clk_en, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk_src);
    // R1
    check(clk_div == 1'b1, "R1 first rise", clk_div, 1);
    repeat (3) @(negedge clk_src);
    check(clk_div == 1'b0, "R1 default divide-by-2", clk_div, 0);

    settle(0, 3);
    settle(3, 1);
    settle(1, 7);
    settle(7, 0);
    // R3
    settle(2, 12);
    settle(15, 4);

    // R6: two writes in one period, last wins
    wait_rise();
    write_sel(6);
    write_sel(2);
    wait_rise();
    wait_rise();
    wait_rise();

    for (int i = 0; i < 400; i++) begin
      int gap, code;
      gap  = int'($urandom_range(0, 30));
      code = int'($urandom_range(0, 15));
      if (code > 5 && $urandom_range(0, 2) != 0) code = code % 6;
      repeat (gap) @(negedge clk_src);
      write_sel(code);
      if ($urandom_range(0, 4) == 0) write_sel(int'($urandom_range(0, 15)));
    end
    write_sel(1);
    repeat (600) @(negedge clk_src);
    done = 1'b1;
  end

  initial begin
    int k;
    k = 0;
    while (!done && k < 190000) begin @(negedge clk_src); k++; end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", k);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule